// File: doc/BRIEF.md
# Registered Unsigned Array Multiplier

This block multiplies two unsigned operands with an explicit gate-level array. The operands are held in input registers. Each row of the array ANDs the multiplicand with one multiplier bit and shifts the result to that bit's weight. A row of full adders then adds this partial product into a running sum, and the finished product goes into an output register. By default the operands are 8 bits wide and the product is 16 bits wide.

The block is meant for datapaths that need a multiply with a fixed two-edge latency and one new result every cycle. A pair presented before clock edge k is captured at edge k. Its product is captured at edge k+1. A synchronous, active-high reset clears both operand registers and the product register.

Top module: `regd_array_mult`

## Requirements
- R1: The product output equals the unsigned product A×B, masked to 16 bits. It appears after the second rising edge following the cycle in which A and B are driven.
- R2: The operand registers sample A and B on every rising edge. After one edge the output still shows the previous pair's product, and the new product appears only after the second edge.
- R3: With rst high at a rising edge, the operand and product registers become zero. After rst is released, the output stays zero through the first following edge.
- R4: Product bit 0 is the AND of bit 0 of A and bit 0 of B.
- R5: If either operand is zero, the product is zero.
- R6: The largest operands, 255×255, give 65025 (0xFE01). The final array row's carry supplies the top product bit.
- R7: The operands 12 and 11 give 132.
- R8: If B has only bit i set, the product is A shifted left by i places. By symmetry, if A has only bit i set, the product is B shifted left by i places.
- R9: A new operand pair may be presented every cycle. Each product appears in order, two edges after its pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Multiplicand, unsigned |
| b_in | input | 8 | Multiplier, unsigned |
| p_out | output | 16 | Registered product |

## Verification
Some properties are checked on every cycle outside reset:
- Each operand register holds the value its input had on the previous cycle.
- The product register holds the arithmetic product of the operand registers from the previous cycle.
- The array's bit 0 equals the AND of the two low operand bits.
- A zero operand gives a zero array result.

The directed scenarios cover what a per-cycle property cannot show. They check the values seen at the ports after reset and after a reset in the middle of a run. They check the two-edge latency as seen from outside, and results for specific operand patterns: the worked example, the largest operands, single-bit shifts, and back-to-back streams.

// File: rtl/amul_pkg.sv
package amul_pkg;

    localparam int AMUL_A_W = 8;
    localparam int AMUL_B_W = 8;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_res_t;

    function automatic fa_res_t fa_eval(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/amul_full_adder.sv
module amul_full_adder
    import amul_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    fa_res_t res;

    always_comb begin
        res = fa_eval(x, y, ci);
    end

    assign s  = res.sum;
    assign co = res.carry;
endmodule

// File: rtl/amul_stage_reg.sv
module amul_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R2: the register follows its input with one edge of delay
    assert_stage_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)));
endmodule

// File: rtl/amul_pp_gen.sv
module amul_pp_gen #(
    parameter int AW = 8,
    parameter int BW = 8
) (
    input  logic [AW-1:0]          mcand,
    input  logic [BW-1:0]          mplier,
    output logic [BW-1:0][AW-1:0]  pp
);
    for (genvar r = 0; r < BW; r++) begin : g_row
        for (genvar c = 0; c < AW; c++) begin : g_bit
            assign pp[r][c] = mcand[c] & mplier[r];
        end
    end
endmodule

// File: rtl/amul_fa_array.sv
module amul_fa_array #(
    parameter int AW = 8,
    parameter int BW = 8,
    localparam int PW = AW + BW
) (
    input  logic [BW-1:0][AW-1:0] pp,
    output logic [PW-1:0]         prod
);
    // Running sum of each row and the carry out of its top adder
    logic [BW-1:0][AW-1:0] acc;
    logic [BW-1:0]         top_c;
    logic [BW-1:1][AW:0]   rip;

    assign acc[0]   = pp[0];
    assign top_c[0] = 1'b0;

    for (genvar r = 1; r < BW; r++) begin : g_row
        assign rip[r][0] = 1'b0;
        for (genvar c = 0; c < AW; c++) begin : g_col
            logic upper;
            if (c == AW - 1) begin : g_msb
                assign upper = top_c[r-1];
            end else begin : g_mid
                assign upper = acc[r-1][c+1];
            end
            amul_full_adder u_fa (
                .x  (upper),
                .y  (pp[r][c]),
                .ci (rip[r][c]),
                .s  (acc[r][c]),
                .co (rip[r][c+1])
            );
        end
        assign top_c[r] = rip[r][AW];
    end

    // The low bit of every row but the last is final, and the last row supplies the rest
    for (genvar r = 0; r < BW - 1; r++) begin : g_low
        assign prod[r] = acc[r][0];
    end
    assign prod[PW-2:BW-1] = acc[BW-1];
    assign prod[PW-1]      = top_c[BW-1];
endmodule

// File: rtl/regd_array_mult.sv
module regd_array_mult
    import amul_pkg::*;
#(
    parameter int AW = AMUL_A_W,
    parameter int BW = AMUL_B_W,
    localparam int PW = AW + BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    output logic [PW-1:0] p_out
);
    logic [AW-1:0]          a_q;
    logic [BW-1:0]          b_q;
    logic [BW-1:0][AW-1:0]  pp;
    logic [PW-1:0]          prod_d;

    amul_stage_reg #(.W(AW)) u_a_reg (.clk(clk), .rst(rst), .d(a_in), .q(a_q));
    amul_stage_reg #(.W(BW)) u_b_reg (.clk(clk), .rst(rst), .d(b_in), .q(b_q));

    amul_pp_gen #(.AW(AW), .BW(BW)) u_pp (
        .mcand  (a_q),
        .mplier (b_q),
        .pp     (pp)
    );

    amul_fa_array #(.AW(AW), .BW(BW)) u_arr (
        .pp   (pp),
        .prod (prod_d)
    );

    amul_stage_reg #(.W(PW)) u_p_reg (.clk(clk), .rst(rst), .d(prod_d), .q(p_out));

    // R1: registered product matches the arithmetic product of last cycle's operands
    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (p_out == PW'({{BW{1'b0}}, $past(a_q)} * {{AW{1'b0}}, $past(b_q)})));

    // R4: the array's lowest bit comes from the two lowest operand bits
    assert_low_bit_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |-> (prod_d[0] == (a_q[0] & b_q[0])));

    // R5: a zero operand gives a zero array result
    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
        ((a_q == '0) || (b_q == '0)) |-> (prod_d == '0));
endmodule

// File: tb/test_regd_array_mult.sv
module test_regd_array_mult;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] p_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regd_array_mult i_regd_array_mult (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .b_in  (b_in),
        .p_out (p_out)
    );

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] acc = '0;
        for (int i = 0; i < 8; i++)
            if (b[i]) acc = acc + (16'(a) << i);
        return acc;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample two falling edges later
    task automatic run_pair(input string req, input logic [7:0] a, input logic [7:0] b,
                            input logic [15:0] exp);
        @(negedge clk);
        a_in = a; b_in = b;
        @(negedge clk);
        @(negedge clk);
        check(req, p_out, exp);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; a_in = 8'hC3; b_in = 8'h5A;
        @(negedge clk);
        check("R3 reset clears product", p_out, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R3 zero one edge after release", p_out, 16'h0000);
        @(negedge clk);
        check("R3 product after release", p_out, ref_mul(8'hC3, 8'h5A));
    endtask

    task automatic t_worked();
        run_pair("R7 12x11", 8'd12, 8'd11, 16'd132);
        run_pair("R1 11x12", 8'd11, 8'd12, 16'd132);
    endtask

    task automatic t_zero();
        run_pair("R5 A zero", 8'h00, 8'hFF, 16'h0000);
        run_pair("R5 B zero", 8'hFF, 8'h00, 16'h0000);
    endtask

    task automatic t_max();
        run_pair("R6 255x255", 8'hFF, 8'hFF, 16'hFE01);
        check("R6 top bit set", {15'b0, p_out[15]}, 16'h0001);
    endtask

    task automatic t_bit0();
        run_pair("R4 odd x odd", 8'h01, 8'h01, 16'h0001);
        check("R4 bit0 odd", {15'b0, p_out[0]}, 16'h0001);
        run_pair("R4 odd x even", 8'hFF, 8'hFE, ref_mul(8'hFF, 8'hFE));
        check("R4 bit0 even", {15'b0, p_out[0]}, 16'h0000);
    endtask

    task automatic t_shift();
        for (int i = 0; i < 8; i++) begin
            run_pair("R8 B single bit", 8'hB7, 8'(1 << i), 16'(16'h00B7 << i));
            run_pair("R8 A single bit", 8'(1 << i), 8'h6D, 16'(16'h006D << i));
        end
    endtask

    task automatic t_latency();
        run_pair("R2 setup pair", 8'd20, 8'd30, 16'd600);
        @(negedge clk);
        a_in = 8'd7; b_in = 8'd9;
        @(negedge clk);
        check("R2 old product after one edge", p_out, 16'd600);
        @(negedge clk);
        check("R2 new product after two edges", p_out, 16'd63);
    endtask

    task automatic t_stream();
        logic [7:0] sa [0:39];
        logic [7:0] sb [0:39];
        logic [7:0] lfsr = 8'h5D;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            sa[k] = lfsr;
            sb[k] = lfsr ^ 8'(k * 37);
        end
        for (int k = 0; k < 42; k++) begin
            @(negedge clk);
            if (k >= 2) check("R9 streamed product", p_out, ref_mul(sa[k-2], sb[k-2]));
            if (k < 40) begin a_in = sa[k]; b_in = sb[k]; end
        end
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 256; a += 17)
            for (int b = 3; b < 256; b += 29)
                run_pair("R1 sweep", 8'(a), 8'(b), 16'(a * b));
    endtask

    task automatic t_mid_reset();
        @(negedge clk); a_in = 8'hE7; b_in = 8'h9B;
        @(negedge clk); @(negedge clk);
        check("R1 before mid reset", p_out, ref_mul(8'hE7, 8'h9B));
        rst = 1'b1;
        @(negedge clk);
        check("R3 mid-run reset clears", p_out, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R3 held zero after mid reset", p_out, 16'h0000);
        @(negedge clk);
        check("R3 recovery product", p_out, ref_mul(8'hE7, 8'h9B));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_worked();
        t_zero();
        t_max();
        t_bit0();
        t_shift();
        t_latency();
        t_stream();
        t_sweep();
        t_mid_reset();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule